// File: doc/BRIEF.md
# Serial Register Write Host

This block is the host side of a three-wire register write link. On a start request it takes a 24-bit data word, a 5-bit register address and a 3-bit chip address and joins them into one 32-bit frame. It then produces the serial clock and the serial data line, and ends the frame with a strobe that tells the target device to commit the word. Data leads the frame, the register address follows, and the chip address comes last. Each field is sent most significant bit first.

The serial data line changes only while the serial clock is low, so every rising edge sees settled data. Once all 32 rising edges have gone out, the clock stays low and the strobe goes high for one half-period, then low again. A single-cycle done pulse marks the end of the frame. The clock rate is set by a parameter that gives the half-period in system-clock cycles. The user picks it so that the serial clock does not exceed 50 MHz and each strobe phase lasts at least 10 ns. The handshake is a start input and a busy output. A start that arrives while a frame is in flight has no effect.

Top module: `ser_wr_host`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sclk`, `sen`, `busy` and `done` are all 0.
- R2: The bit sampled on rising edge k (k = 1..32) of `sclk` is bit 32-k of the frame {`wr_data`, `wr_reg`, `wr_chip`}. Data bits 23..0 go out on edges 1-24, register bits 4..0 on edges 25-29, and chip bits 2..0 on edges 30-32.
- R3: `sdi` only changes while `sclk` is low. It holds its value for the whole time `sclk` is high.
- R4: Each high phase and each low phase of `sclk` lasts exactly HALF_DIV system-clock cycles. The first rising edge comes HALF_DIV cycles after the cycle in which start is accepted.
- R5: Each frame has exactly 32 rising edges of `sclk` before `sen` rises.
- R6: `sen` rises at the same clock edge at which `sclk` falls after its 32nd rising edge, which is one half-period after that edge. `sclk` stays low while `sen` is high.
- R7: `sen` stays high for exactly HALF_DIV cycles. `done` is high for exactly one cycle: the first cycle in which `sen` is low again.
- R8: `busy` goes high in the cycle after a start is accepted while idle. It stays high until `sen` falls. A start that arrives while `busy` is high changes neither the frame being sent nor the number of frames sent.
- R9: HALF_DIV must be at least 1, and each field width must be at least 1; elaboration stops otherwise. HALF_DIV = 1 gives a serial clock of half the system clock.
- R10: While `busy` is low, `sclk` and `sen` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send one frame; sampled only while idle |
| wr_data | input | 24 | Data word, captured at start |
| wr_reg | input | 5 | Register address, captured at start |
| wr_chip | input | 3 | Chip address, captured at start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sclk | output | 1 | Serial clock, idles low |
| sdi | output | 1 | Serial data, changes while sclk is low |
| sen | output | 1 | End-of-frame strobe, high for one half-period |

## Verification
The hardest case to reach from the ports is a start that lands exactly in the done cycle. In that cycle `busy` has just dropped and `sen` has only just fallen. The sequencer must go straight from the strobe phase into a new frame without losing a low phase or skipping the first bit. The driver waits for `busy` to drop and raises start in that same cycle, so frames run back to back. A second start, with different field values, is raised in the middle of a frame. The scoreboard then confirms that the frame in flight and the frame count are unchanged.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_CLOCK = 2'd1,
      SEQ_STROBE = 2'd2
   } seq_state_t;

endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_direct
         // every cycle is a half-period boundary
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && (cnt_q == LAST);

         // R4
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && run) |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] frame_in,
   output logic         sdo
);

   logic [W-1:0] sreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg_q <= '0;
      else if (load)
         sreg_q <= frame_in;
      else if (shift)
         sreg_q <= {sreg_q[W-2:0], 1'b0};
   end

   assign sdo = sreg_q[W-1];

   // R2
   first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sdo == $past(frame_in[W-1])));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !shift) |=> $stable(sdo));

endmodule

// File: rtl/frame_seq.sv
module frame_seq
   import ser_wr_pkg::*;
#(
   parameter int FRAME_W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic load,
   output logic shift,
   output logic busy,
   output logic done,
   output logic sclk,
   output logic sen
);

   localparam int BW = $clog2(FRAME_W);
   localparam int RW = $clog2(FRAME_W + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

   seq_state_t    state_q;
   logic [BW-1:0] bit_q;
   logic [RW-1:0] rise_q;
   logic          last_fall;

   assign load      = (state_q == SEQ_IDLE) && start;
   assign last_fall = (state_q == SEQ_CLOCK) && tick && sclk && (bit_q == LAST_BIT);
   assign shift     = (state_q == SEQ_CLOCK) && tick && sclk && (bit_q != LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         bit_q   <= '0;
         rise_q  <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         sclk    <= 1'b0;
         sen     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_CLOCK;
                  bit_q   <= '0;
                  rise_q  <= '0;
                  busy    <= 1'b1;
                  sclk    <= 1'b0;
               end
            end
            SEQ_CLOCK: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk   <= 1'b1;
                     rise_q <= rise_q + 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (last_fall) begin
                        sen     <= 1'b1;
                        state_q <= SEQ_STROBE;
                     end else begin
                        bit_q <= bit_q + 1'b1;
                     end
                  end
               end
            end
            SEQ_STROBE: begin
               if (tick) begin
                  sen     <= 1'b0;
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  state_q <= SEQ_IDLE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R5
   edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sen) |-> (rise_q == RW'(FRAME_W)));

   // R6
   sen_quiet_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sen |-> !sclk);

   // R6
   sen_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sen) |-> $fell(sclk));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_at_sen_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(sen) && !busy));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !sen));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && (state_q != SEQ_STROBE)) |=> busy);

endmodule

// File: rtl/ser_wr_host.sv
module ser_wr_host #(
   parameter int DATA_W   = 24,
   parameter int REG_W    = 5,
   parameter int CHIP_W   = 3,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_W-1:0]  wr_reg,
   input  logic [CHIP_W-1:0] wr_chip,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              sdi,
   output logic              sen
);

   localparam int FRAME_W = DATA_W + REG_W + CHIP_W;

   // R9
   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("ser_wr_host: HALF_DIV must be at least 1");
      end
      if (DATA_W < 1 || REG_W < 1 || CHIP_W < 1) begin : g_bad_width
         $error("ser_wr_host: every field width must be at least 1");
      end
   endgenerate

   logic               tick;
   logic               load;
   logic               shift;
   logic [FRAME_W-1:0] frame;

   assign frame = {wr_data, wr_reg, wr_chip};

   sclk_tick_gen #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   frame_seq #(
      .FRAME_W (FRAME_W)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .tick  (tick),
      .load  (load),
      .shift (shift),
      .busy  (busy),
      .done  (done),
      .sclk  (sclk),
      .sen   (sen)
   );

   frame_shifter #(
      .W (FRAME_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .shift    (shift),
      .frame_in (frame),
      .sdo      (sdi)
   );

   // R3
   sdi_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdi));

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

endmodule

// File: tb/ser_wr_host_tb_top.sv
module ser_wr_host_tb_top;

   localparam int H = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] wr_data = '0;
   logic [4:0]  wr_reg = '0;
   logic [2:0]  wr_chip = '0;
   logic        busy, done, sclk, sdi, sen;

   int checks = 0;
   int fails = 0;
   int pushed = 0;
   int frames = 0;
   logic [31:0] exp_q[$];

   always #10 clk = ~clk;

   ser_wr_host #(.HALF_DIV(H)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .wr_data(wr_data), .wr_reg(wr_reg), .wr_chip(wr_chip),
      .busy(busy), .done(done), .sclk(sclk), .sdi(sdi), .sen(sen)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // driver: waits for idle, requests a frame, pushes its expected content
   task automatic send(input logic [23:0] d, input logic [4:0] r, input logic [2:0] c);
      @(negedge clk);
      while (busy) @(negedge clk);
      wr_data = d; wr_reg = r; wr_chip = c; start = 1'b1;
      exp_q.push_back({d, r, c});
      pushed++;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8 busy after accept", {31'd0, busy}, 32'd1);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // monitor / scoreboard
   initial begin
      logic prev_sclk, prev_sen, prev_done, prev_busy, held;
      int low_run, high_run, sen_run, edges;
      logic [31:0] got, exp;
      prev_sclk = 0; prev_sen = 0; prev_done = 0; prev_busy = 0; held = 0;
      low_run = 0; high_run = 0; sen_run = 0; edges = 0; got = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (busy && !prev_busy) begin
               low_run = 1; edges = 0;
            end else if (sclk && !prev_sclk) begin
               chk(low_run == H, "R4 low phase", low_run, H);
               edges++;
               got = {got[30:0], sdi};
               held = sdi;
               high_run = 1;
            end else if (sclk) begin
               high_run++;
               chk(sdi == held, "R3 sdi stable while sclk high", {31'd0, sdi}, {31'd0, held});
            end else if (prev_sclk) begin
               chk(high_run == H, "R4 high phase", high_run, H);
               low_run = 1;
            end else if (busy) begin
               low_run++;
            end

            if (sen && !prev_sen) begin
               chk(prev_sclk && !sclk, "R6 sen rises with last sclk fall",
                   {30'd0, prev_sclk, sclk}, 32'd2);
               chk(edges == 32, "R5 rising edge count", edges, 32);
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8 unexpected frame", got, 32'd0);
               end else begin
                  exp = exp_q.pop_front();
                  chk(got == exp, "R2 frame bits", got, exp);
               end
               sen_run = 1;
            end else if (sen) begin
               sen_run++;
               chk(!sclk, "R6 sclk low while sen high", {31'd0, sclk}, 32'd0);
            end

            if (!sen && prev_sen) begin
               chk(sen_run == H, "R7 sen high length", sen_run, H);
               chk(done, "R7 done with sen fall", {31'd0, done}, 32'd1);
               chk(!busy, "R8 busy drops at sen fall", {31'd0, busy}, 32'd0);
               frames++;
            end
            if (prev_done)
               chk(!done, "R7 done one cycle", {31'd0, done}, 32'd0);
            if (!busy)
               chk(!sclk && !sen, "R10 idle lines low", {30'd0, sclk, sen}, 32'd0);
         end
         prev_sclk = sclk; prev_sen = sen; prev_done = done; prev_busy = busy;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired frames=%0d expected=%0d", frames, pushed);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk({sclk, sen, busy, done} == 4'b0, "R1 reset outputs", {28'd0, sclk, sen, busy, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sclk, sen, busy, done} == 4'b0, "R1 after reset", {28'd0, sclk, sen, busy, done}, 32'd0);

      send(24'hA5C3_0F, 5'h15, 3'b101);
      wait_idle();
      send(24'hFFFFFF, 5'h1F, 3'b111);
      wait_idle();
      send(24'h000000, 5'h00, 3'b000);
      wait_idle();

      // R8 start while busy is ignored
      send(24'h123456, 5'h0A, 3'b011);
      repeat (20) @(negedge clk);
      wr_data = 24'hDEAD00; wr_reg = 5'h11; wr_chip = 3'b110; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8 still busy after ignored start", {31'd0, busy}, 32'd1);
      wait_idle();
      chk(frames == pushed, "R8 no extra frame from ignored start", frames, pushed);

      // back-to-back frames, start in the done cycle
      send(24'h555555, 5'h0B, 3'b010);
      send(24'hAAAAAA, 5'h14, 3'b001);
      send(24'h800001, 5'h10, 3'b100);
      wait_idle();

      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      chk(frames == pushed, "R5 frame count", frames, pushed);
      summary();
      $finish;
   end

endmodule